// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block holds a small set of address translations in a fully associative array. Every slot is tagged with a page-aligned virtual address, a page-size code, a partition number, a context number and a flag marking the mapping as real, meaning it applies to untranslated addresses. A lookup compares all slots at once. On a hit it returns the slot number, the stored page-table entry and the physical address.

New mappings are written with an insert command. The insert first removes every mapping that overlaps the new page. It then takes a free slot, or the lowest slot not recently used, unless the caller names a slot. Three maintenance commands remove mappings in bulk: by context, by partition, or all at once. A side port reads any slot's tag word or data word by index.

The slot count `ENTRIES` is limited to the range 2 to 64. Any other value stops elaboration. Replacement keeps one not-recently-used bit per slot.

Top module: `assoc_xlat_buf`

## Requirements
- R1: With the lookup inputs applied, `lk_hit` rises and `lk_idx`/`lk_pte` show the lowest matching slot in the same cycle. A slot matches when it is valid and has the same real flag and partition, the request address agrees with its stored address above the page-offset bits, and either the slot is real or its context equals `lk_ctx`.
- R2: On a hit, `lk_pa` is the entry's physical page (entry bits [39:13]) with the page-offset bits taken from the request address. The offset is the low 13 + 3·size bits, where size is entry bits [2:1]: code 0 = 8 KiB, 1 = 64 KiB, 2 = 512 KiB, 3 = 4 MiB. On a miss, `lk_pa` is zero.
- R3: An insert stores the virtual address with the offset bits of its own page size cleared.
- R4: An insert invalidates every valid slot that has the same real flag and partition, whose address range overlaps the new page, and whose context matches, unless the new mapping is real.
- R5: An insert writes to `ins_idx` when `ins_fixed` is set. Otherwise it writes to the lowest free slot, where slots freed by R4 count as free. If no slot is free, it writes to the lowest slot whose used bit is clear.
- R6: An insert sets the target slot's used bit. A lookup with `lk_touch` set sets the hit slot's used bit, and a lookup without it changes nothing. When a set would leave every bit set, all bits are cleared except the one just set.
- R7: The context demap clears the valid and used bits of every slot whose context and partition equal `dm_ctx` and `dm_part`.
- R8: The partition demap clears every valid slot of partition `dm_part` whose lock bit (entry bit 0) is clear. Locked slots stay.
- R9: Invalidate-all clears every valid and used bit. Reset leaves the same state.
- R10: `rd_data` returns the stored entry of slot `rd_idx`, or all ones if that slot is invalid.
- R11: `rd_tag` returns the context OR the stored address OR the partition shifted to bit 61, or all ones if the slot is invalid.
- R12: Only one command is carried out per cycle, in the priority invalidate-all, partition demap, context demap, insert. A lookup's used-bit update is dropped in any cycle that carries a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_en | input | 1 | Insert command |
| ins_va | input | VA_W | Insert virtual address |
| ins_part | input | PART_W | Insert partition |
| ins_ctx | input | CTX_W | Insert context |
| ins_real | input | 1 | Insert real flag |
| ins_pte | input | 64 | Insert page-table entry |
| ins_fixed | input | 1 | Use ins_idx as the target slot |
| ins_idx | input | IW | Explicit target slot |
| lk_va | input | VA_W | Lookup address |
| lk_part | input | PART_W | Lookup partition |
| lk_ctx | input | CTX_W | Lookup context |
| lk_real | input | 1 | Lookup real flag |
| lk_touch | input | 1 | Lookup updates the used bit |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IW | Hit slot |
| lk_pte | output | 64 | Hit entry, zero on miss |
| lk_pa | output | PA_W | Translated physical address |
| dmc_en | input | 1 | Context demap command |
| dma_en | input | 1 | Partition demap command |
| inv_en | input | 1 | Invalidate-all command |
| dm_part | input | PART_W | Demap partition |
| dm_ctx | input | CTX_W | Demap context |
| rd_idx | input | IW | Read slot |
| rd_tag | output | 64 | Tag word of slot rd_idx |
| rd_data | output | 64 | Entry of slot rd_idx |

## Verification
An updating lookup and an insert can fall in the same cycle, and so can two maintenance commands. The bench issues an insert while a touching lookup hits a slot that would otherwise become used. It then fills the array and checks where a later insert lands: if the touch had wrongly taken effect, the victim would move. A partition demap is also issued together with a context demap that would remove a locked slot, and invalidate-all is issued together with an insert. Each outcome is judged by reading the slots back.

// File: rtl/assoc_xlat_buf.sv
module assoc_xlat_buf #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 64,
  parameter int PA_W    = 40,
  parameter int CTX_W   = 13,
  parameter int PART_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_en,
  input  logic [VA_W-1:0]            ins_va,
  input  logic [PART_W-1:0]          ins_part,
  input  logic [CTX_W-1:0]           ins_ctx,
  input  logic                       ins_real,
  input  logic [63:0]                ins_pte,
  input  logic                       ins_fixed,
  input  logic [$clog2(ENTRIES)-1:0] ins_idx,
  input  logic [VA_W-1:0]            lk_va,
  input  logic [PART_W-1:0]          lk_part,
  input  logic [CTX_W-1:0]           lk_ctx,
  input  logic                       lk_real,
  input  logic                       lk_touch,
  output logic                       lk_hit,
  output logic [$clog2(ENTRIES)-1:0] lk_idx,
  output logic [63:0]                lk_pte,
  output logic [PA_W-1:0]            lk_pa,
  input  logic                       dmc_en,
  input  logic                       dma_en,
  input  logic                       inv_en,
  input  logic [PART_W-1:0]          dm_part,
  input  logic [CTX_W-1:0]           dm_ctx,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [63:0]                rd_tag,
  output logic [63:0]                rd_data
);
  localparam int IW = $clog2(ENTRIES);

  if (ENTRIES > 64 || ENTRIES < 2) begin : g_bad_size
    $error("assoc_xlat_buf: ENTRIES must lie between 2 and 64");
  end

  function automatic logic [VA_W-1:0] lomask(input logic [1:0] sz);
    return (VA_W'(1) << (13 + 3 * int'(sz))) - VA_W'(1);
  endfunction

  function automatic logic [IW-1:0] first_set(input logic [ENTRIES-1:0] v);
    first_set = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) first_set = IW'(i);
  endfunction

  logic [ENTRIES-1:0] vld, used, vld_n, used_n, e_real;
  logic [VA_W-1:0]    e_va   [ENTRIES];
  logic [CTX_W-1:0]   e_ctx  [ENTRIES];
  logic [PART_W-1:0]  e_part [ENTRIES];
  logic [63:0]        e_pte  [ENTRIES];

  logic [ENTRIES-1:0] hit_v, ovl_v, dmc_v, dma_v;
  logic [VA_W-1:0]    n_msk;
  assign n_msk = lomask(ins_pte[2:1]);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [VA_W-1:0] m;
    assign m = lomask(e_pte[g][2:1]);
    assign hit_v[g] = vld[g] && e_real[g] == lk_real && e_part[g] == lk_part &&
                      ((lk_va ^ e_va[g]) & ~m) == '0 && (e_real[g] || e_ctx[g] == lk_ctx);
    assign ovl_v[g] = vld[g] && e_real[g] == ins_real && e_part[g] == ins_part &&
                      ((ins_va ^ e_va[g]) & ~(m | n_msk)) == '0 &&
                      (ins_real || e_ctx[g] == ins_ctx);
    assign dmc_v[g] = e_ctx[g] == dm_ctx && e_part[g] == dm_part;
    assign dma_v[g] = vld[g] && !e_pte[g][0] && e_part[g] == dm_part;
  end

  logic [IW-1:0] hit_idx, victim;
  logic [63:0]   h_pte;
  logic [PA_W-1:0] pm;
  logic [ENTRIES-1:0] free;

  assign hit_idx = first_set(hit_v);
  assign lk_hit  = |hit_v;
  assign lk_idx  = hit_idx;
  assign h_pte   = e_pte[hit_idx];
  assign lk_pte  = lk_hit ? h_pte : '0;
  assign pm      = PA_W'(lomask(h_pte[2:1]));
  assign lk_pa   = lk_hit ? (({h_pte[PA_W-1:13], 13'b0} & ~pm) | (lk_va[PA_W-1:0] & pm)) : '0;

  assign free   = ~vld | ovl_v;
  assign victim = ins_fixed ? ins_idx : (|free ? first_set(free) : first_set(~used));

  logic any_cmd, do_dma, do_dmc, do_ins, do_touch;
  assign any_cmd  = ins_en | inv_en | dma_en | dmc_en;
  assign do_dma   = dma_en & ~inv_en;
  assign do_dmc   = dmc_en & ~inv_en & ~dma_en;
  assign do_ins   = ins_en & ~inv_en & ~dma_en & ~dmc_en;
  assign do_touch = lk_touch & lk_hit & ~any_cmd;

  always_comb begin
    vld_n  = vld;
    used_n = used;
    if (inv_en) begin
      vld_n  = '0;
      used_n = '0;
    end else if (do_dma) begin
      vld_n  = vld & ~dma_v;
      used_n = used & ~dma_v;
    end else if (do_dmc) begin
      vld_n  = vld & ~dmc_v;
      used_n = used & ~dmc_v;
    end else if (do_ins) begin
      vld_n  = (vld & ~ovl_v) | (ENTRIES'(1) << victim);
      used_n = (used & ~ovl_v) | (ENTRIES'(1) << victim);
      if (&used_n) used_n = ENTRIES'(1) << victim;
    end else if (do_touch) begin
      used_n = used | (ENTRIES'(1) << hit_idx);
      if (&used_n) used_n = ENTRIES'(1) << hit_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      used <= '0;
    end else begin
      vld  <= vld_n;
      used <= used_n;
      if (do_ins) begin
        e_va[victim]   <= ins_va & ~n_msk;
        e_ctx[victim]  <= ins_ctx;
        e_part[victim] <= ins_part;
        e_real[victim] <= ins_real;
        e_pte[victim]  <= ins_pte;
      end
    end
  end

  assign rd_data = vld[rd_idx] ? e_pte[rd_idx] : '1;
  assign rd_tag  = vld[rd_idx] ? (64'(e_ctx[rd_idx]) | 64'(e_va[rd_idx]) |
                                  (64'(e_part[rd_idx]) << 61)) : '1;

  assert_hit_is_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> vld[lk_idx]);
  assert_fixed_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && ins_fixed && !inv_en && !dma_en && !dmc_en) |=> vld[$past(ins_idx)]);
  assert_used_within_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (used & ~vld) == '0);
  assert_never_all_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&used));
  assert_inv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> (vld == '0 && used == '0));
endmodule

// File: tb/test_assoc_xlat_buf.sv
module test_assoc_xlat_buf;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic ins_en = 0, ins_real = 0, ins_fixed = 0, lk_real = 0, lk_touch = 0;
  logic dmc_en = 0, dma_en = 0, inv_en = 0;
  logic [63:0] ins_va = 0, ins_pte = 0, lk_va = 0;
  logic [2:0] ins_part = 0, lk_part = 0, dm_part = 0;
  logic [12:0] ins_ctx = 0, lk_ctx = 0, dm_ctx = 0;
  logic [IW-1:0] ins_idx = 0, rd_idx = 0;
  logic lk_hit;
  logic [IW-1:0] lk_idx;
  logic [63:0] lk_pte, rd_tag, rd_data;
  logic [39:0] lk_pa;

  int checks = 0, fails = 0;
  bit done = 0;

  assoc_xlat_buf #(.ENTRIES(N)) i_assoc_xlat_buf (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h @%0t", rq, act, exp, $time);
    end
  endtask

  // reference model
  bit mv[N], mu[N], mr[N];
  longint unsigned mva[N], mpte[N];
  int mctx[N], mpart[N];

  function automatic longint unsigned msk(input int sz);
    return (64'd1 << (13 + 3 * sz)) - 64'd1;
  endfunction

  function automatic void mlook(input longint unsigned va, input int p, input int c, input bit r,
                                output bit hit, output int idx);
    hit = 0; idx = 0;
    for (int i = 0; i < N; i++)
      if (!hit && mv[i] && mr[i] == r && mpart[i] == p &&
          (va & ~msk(int'(mpte[i][2:1]))) == mva[i] && (mr[i] || mctx[i] == c)) begin
        hit = 1; idx = i;
      end
  endfunction

  function automatic void mfull(input int keep);
    int cnt = 0;
    for (int i = 0; i < N; i++) cnt += int'(mu[i]);
    if (cnt == N) begin
      for (int i = 0; i < N; i++) mu[i] = 0;
      mu[keep] = 1;
    end
  endfunction

  task automatic model_step();
    bit hit; int hi; int v;
    longint unsigned m, a;
    if (inv_en) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mu[i] = 0; end
    end else if (dma_en) begin
      for (int i = 0; i < N; i++)
        if (mv[i] && !mpte[i][0] && mpart[i] == int'(dm_part)) begin mv[i] = 0; mu[i] = 0; end
    end else if (dmc_en) begin
      for (int i = 0; i < N; i++)
        if (mctx[i] == int'(dm_ctx) && mpart[i] == int'(dm_part)) begin mv[i] = 0; mu[i] = 0; end
    end else if (ins_en) begin
      m = msk(int'(ins_pte[2:1]));
      a = ins_va & ~m;
      for (int i = 0; i < N; i++)
        if (mv[i] && mr[i] == ins_real && mpart[i] == int'(ins_part) &&
            mva[i] <= a + m && mva[i] + msk(int'(mpte[i][2:1])) >= a &&
            (ins_real || mctx[i] == int'(ins_ctx))) begin
          mv[i] = 0; mu[i] = 0;
        end
      v = -1;
      if (ins_fixed) v = int'(ins_idx);
      for (int i = 0; i < N; i++) if (v < 0 && !mv[i]) v = i;
      for (int i = 0; i < N; i++) if (v < 0 && !mu[i]) v = i;
      mv[v] = 1; mu[v] = 1; mva[v] = a; mpte[v] = ins_pte;
      mctx[v] = int'(ins_ctx); mpart[v] = int'(ins_part); mr[v] = ins_real;
      mfull(v);
    end else if (lk_touch) begin
      mlook(lk_va, int'(lk_part), int'(lk_ctx), lk_real, hit, hi);
      if (hit) begin mu[hi] = 1; mfull(hi); end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < N; i++) begin mv[i] = 0; mu[i] = 0; end
    else model_step();
  end

  always @(negedge clk) begin
    bit hit; int hi;
    longint unsigned m, ep, et;
    if (rst_n && !done) begin
      mlook(lk_va, int'(lk_part), int'(lk_ctx), lk_real, hit, hi);
      chk(lk_hit == hit, "R1 hit", 64'(lk_hit), 64'(hit));
      if (hit) begin
        m = msk(int'(mpte[hi][2:1]));
        chk(int'(lk_idx) == hi, "R1 idx", 64'(lk_idx), 64'(hi));
        chk(lk_pte == mpte[hi], "R1 pte", lk_pte, mpte[hi]);
        ep = ((mpte[hi] & ~m) | (lk_va & m)) & 64'hFF_FFFF_FFFF;
        chk(64'(lk_pa) == ep, "R2 pa", 64'(lk_pa), ep);
      end
      ep = mv[rd_idx] ? mpte[rd_idx] : '1;
      et = mv[rd_idx] ? (64'(mctx[rd_idx]) | mva[rd_idx] | (64'(mpart[rd_idx]) << 61)) : '1;
      chk(rd_data == ep, "R10 data", rd_data, ep);
      chk(rd_tag == et, "R11 tag", rd_tag, et);
    end
  end

  function automatic logic [63:0] tg(input int p, input int c, input logic [63:0] va);
    return 64'(c) | va | (64'(p) << 61);
  endfunction

  function automatic logic [63:0] pte(input logic [63:0] pa, input int sz, input bit lk);
    return pa | (64'(sz) << 1) | 64'(lk);
  endfunction

  task automatic ins(input logic [63:0] va, input int p, input int c, input bit r,
                     input logic [63:0] d);
    ins_va = va; ins_part = 3'(p); ins_ctx = 13'(c); ins_real = r; ins_pte = d; ins_en = 1;
    @(posedge clk); #1;
    ins_en = 0; ins_fixed = 0; inv_en = 0; dma_en = 0; dmc_en = 0; lk_touch = 0;
  endtask

  task automatic probe(input logic [63:0] va, input int p, input int c, input bit r, input bit t);
    lk_va = va; lk_part = 3'(p); lk_ctx = 13'(c); lk_real = r; lk_touch = t;
    @(negedge clk); #1;
  endtask

  task automatic rd(input int i);
    rd_idx = IW'(i);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(0);
    chk(rd_data == '1, "R9 reset data", rd_data, '1);
    chk(rd_tag == '1, "R9 reset tag", rd_tag, '1);
    probe(64'h12000, 1, 5, 0, 0);
    chk(lk_hit == 0, "R9 reset miss", 64'(lk_hit), 0);
    @(posedge clk); #1;

    ins(64'h12345, 1, 5, 0, pte(64'h40_0000, 0, 0));
    rd(0);
    chk(rd_tag == tg(1, 5, 64'h12000), "R3 aligned tag", rd_tag, tg(1, 5, 64'h12000));
    chk(rd_data == pte(64'h40_0000, 0, 0), "R10 stored pte", rd_data, pte(64'h40_0000, 0, 0));
    probe(64'h13FFF, 1, 5, 0, 0);
    chk(lk_hit && lk_idx == 0, "R1 hit A", 64'(lk_idx), 0);
    chk(lk_pa == 40'h40_1FFF, "R2 pa A", 64'(lk_pa), 64'h40_1FFF);
    probe(64'h13FFF, 1, 6, 0, 0);
    chk(!lk_hit, "R1 ctx miss", 64'(lk_hit), 0);
    probe(64'h13FFF, 2, 5, 0, 0);
    chk(!lk_hit, "R1 part miss", 64'(lk_hit), 0);
    @(posedge clk); #1;

    ins(64'h20000, 1, 5, 0, pte(64'h80_0000, 1, 0));
    probe(64'h2ABCD, 1, 5, 0, 0);
    chk(lk_hit && lk_idx == 1, "R5 lowest free", 64'(lk_idx), 1);
    chk(lk_pa == 40'h80_ABCD, "R2 pa 64K", 64'(lk_pa), 64'h80_ABCD);
    @(posedge clk); #1;
    ins(64'h100000, 1, 9, 1, pte(64'hA0_0000, 0, 0));
    probe(64'h100010, 1, 3, 1, 0);
    chk(lk_hit && lk_idx == 2, "R1 real ignores ctx", 64'(lk_idx), 2);
    @(posedge clk); #1;
    ins(64'h40000, 1, 5, 0, pte(64'hB0_0000, 0, 1));
    ins(64'h50000, 1, 5, 0, pte(64'hB2_0000, 0, 0));
    rd(0);
    chk(rd_tag == tg(1, 5, 64'h50000), "R6 replace after bulk clear", rd_tag, tg(1, 5, 64'h50000));

    probe(64'h20000, 1, 5, 0, 0);
    @(posedge clk); #1;
    probe(64'h100000, 1, 0, 1, 1);
    @(posedge clk); #1;
    lk_touch = 0;
    ins(64'h60000, 1, 5, 0, pte(64'hB4_0000, 0, 0));
    rd(1);
    chk(rd_tag == tg(1, 5, 64'h60000), "R6 probe leaves used", rd_tag, tg(1, 5, 64'h60000));
    ins(64'h70000, 1, 5, 0, pte(64'hB6_0000, 0, 0));
    rd(0);
    chk(rd_tag == tg(1, 5, 64'h70000), "R5 lowest unused", rd_tag, tg(1, 5, 64'h70000));

    ins(64'h40000, 1, 5, 0, pte(64'hC0_0000, 2, 0));
    rd(1);
    chk(rd_tag == '1, "R4 overlap evicted 1", rd_tag, '1);
    rd(3);
    chk(rd_tag == '1, "R4 overlap evicted 3", rd_tag, '1);
    rd(2);
    chk(rd_tag == tg(1, 9, 64'h100000), "R4 real kept", rd_tag, tg(1, 9, 64'h100000));
    rd(0);
    chk(rd_tag == tg(1, 5, 64'h0), "R3 large page aligned", rd_tag, tg(1, 5, 64'h0));

    lk_va = 64'h100000; lk_part = 1; lk_real = 1; lk_touch = 1;
    ins(64'h200000, 1, 7, 0, pte(64'hD0_0000, 0, 0));
    ins(64'h300000, 1, 7, 0, pte(64'hD2_0000, 0, 0));
    ins(64'h400000, 1, 7, 0, pte(64'hD4_0000, 0, 0));
    rd(2);
    chk(rd_tag == tg(1, 7, 64'h400000), "R12 touch dropped with insert", rd_tag, tg(1, 7, 64'h400000));

    dm_part = 1; dm_ctx = 7; dmc_en = 1;
    @(posedge clk); #1; dmc_en = 0;
    rd(1);
    chk(rd_tag == '1, "R7 ctx demap", rd_tag, '1);
    rd(0);
    chk(rd_tag == tg(1, 5, 64'h0), "R7 other ctx kept", rd_tag, tg(1, 5, 64'h0));
    probe(64'h12345, 1, 5, 0, 0);
    chk(lk_pa == 40'hC1_2345, "R2 pa 512K", 64'(lk_pa), 64'hC1_2345);
    @(posedge clk); #1;

    ins(64'h500000, 2, 7, 0, pte(64'hE0_0000, 0, 0));
    ins(64'h800000, 1, 3, 0, pte(64'hE2_0000, 0, 1));
    ins(64'h600000, 1, 3, 0, pte(64'hE4_0000, 0, 0));
    dm_part = 1; dm_ctx = 3; dma_en = 1; dmc_en = 1;
    @(posedge clk); #1; dma_en = 0; dmc_en = 0;
    rd(0);
    chk(rd_tag == '1, "R8 unlocked removed", rd_tag, '1);
    rd(3);
    chk(rd_tag == '1, "R8 unlocked removed 3", rd_tag, '1);
    rd(2);
    chk(rd_tag == tg(1, 3, 64'h800000), "R8 locked kept R12", rd_tag, tg(1, 3, 64'h800000));
    rd(1);
    chk(rd_tag == tg(2, 7, 64'h500000), "R8 other partition kept", rd_tag, tg(2, 7, 64'h500000));

    inv_en = 1;
    ins(64'h900000, 1, 1, 0, pte(64'hF0_0000, 0, 0));
    for (int i = 0; i < N; i++) begin
      rd(i);
      chk(rd_tag == '1, "R9 invalidate-all R12", rd_tag, '1);
    end

    ins_fixed = 1; ins_idx = 2;
    ins(64'hA00000, 3, 4, 0, pte(64'hF2_0000, 0, 0));
    rd(2);
    chk(rd_tag == tg(3, 4, 64'hA00000), "R5 fixed slot", rd_tag, tg(3, 4, 64'hA00000));
    ins(64'hB00000, 3, 4, 0, pte(64'hF4_0000, 0, 0));
    rd(0);
    chk(rd_tag == tg(3, 4, 64'hB00000), "R5 free after fixed", rd_tag, tg(3, 4, 64'hB00000));

    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule